// File: doc/BRIEF.md
# Pin Pull Configuration Bank

This block keeps, for every pin of a 134-pin general-purpose bank, one pull-enable bit and one pull-direction bit. It drives a pull-up enable and a pull-down enable per pin toward the pad ring. The bits are grouped into 16-bit words. Software changes them only through separate set and clear alias addresses. Because writing a 1 touches only that bit, a single pin is reprogrammed without a read-modify-write sequence.

Each word owns a group of eight addresses. Two of them read back the stored enable word and the stored direction word. Four are write-only aliases. The remaining two are unused. Several pin ranges have their pulls managed by another controller. Their enable bits are wired to zero, so nothing written here ever makes those pins pull. Software that wants a pull first writes the direction alias and then the enable alias, so the pin never pulls the wrong way, even for a moment.

Top module: `pad_pull_bank`

## Requirements
- R1: After a synchronous reset every stored enable and direction bit is 0, so all pull_up and pull_down outputs are 0 and every readable word reads 0.
- R2: Pin p maps to word p/16, bit p%16. The byte-free address is word*8 + slot, with slot 0 = enable readback, 1 = enable set, 2 = enable clear, 4 = direction readback, 5 = direction set (pull-up), 6 = direction clear (pull-down). Slots 3 and 7 are unused.
- R3: Writing a 1 to a bit of the enable-set slot turns pulling on for that pin at the next clock edge. Bits written as 0 leave the state unchanged.
- R4: Writing a 1 to a bit of the enable-clear slot turns pulling off for that pin. Bits written as 0 leave the state unchanged.
- R5: Writing a 1 to the direction-set slot selects pull-up and writing a 1 to the direction-clear slot selects pull-down. The direction is stored even while the enable bit is 0.
- R6: For every pin, pull_up = enable AND direction, and pull_down = enable AND NOT direction.
- R7: The enable bits of pins 22-27, 47-68, 73-78, 100-105 and 119-124 stay 0 whatever is written. Those pins never assert pull_up or pull_down.
- R8: A read with rd_en high loads rd_data at the next edge. Slots 0 and 4 return the stored word. Alias slots, unused slots and word indices 9 and above return 0.
- R9: Writes to readback slots, unused slots or word indices 9 and above change no state.
- R10: Bit positions of the last word that belong to pin numbers 134 and above read 0 in both words and can never be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; rd_data updates at the next edge |
| addr | input | 7 | Word index (upper bits) and slot (lower 3 bits) |
| wdata | input | 16 | Write data, one bit per pin of the word |
| rd_data | output | 16 | Registered read data |
| pull_up | output | 134 | Per-pin pull-up enable |
| pull_down | output | 134 | Per-pin pull-down enable |

## Verification
A wrong stored bit shows on the pull_up or pull_down output of its pin one clock edge after the write that caused it. It also shows on rd_data one edge after a readback of its word. The bench therefore compares all 268 outputs against an independent model after every write. A misdecoded alias or a wrong reserved-range mask appears as a mismatch at the very next comparison. A leak through the unused slots or the out-of-range word indices appears as an unexpected change in the full output vectors, not only in the pin that was addressed.

// File: rtl/pad_pull_pkg.sv
package pad_pull_pkg;

    localparam int DEF_PINS   = 134;
    localparam int DEF_WORD_W = 16;
    localparam int SLOT_W     = 3;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_EN_VAL  = 3'd0,
        SLOT_EN_SET  = 3'd1,
        SLOT_EN_CLR  = 3'd2,
        SLOT_SEL_VAL = 3'd4,
        SLOT_SEL_SET = 3'd5,
        SLOT_SEL_CLR = 3'd6
    } slot_e;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic sel_set;
        logic sel_clr;
    } word_op_t;

    function automatic int words_for(input int pins, input int width);
        return (pins + width - 1) / width;
    endfunction

    // Pins whose pulls belong to another controller.
    function automatic logic pin_reserved(input int p);
        return (p >= 22  && p <= 27)  ||
               (p >= 47  && p <= 68)  ||
               (p >= 73  && p <= 78)  ||
               (p >= 100 && p <= 105) ||
               (p >= 119 && p <= 124);
    endfunction

endpackage

// File: rtl/pad_pull_decode.sv
module pad_pull_decode
    import pad_pull_pkg::*;
#(
    parameter int WORDS  = 9,
    parameter int ADDR_W = 7
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORDS-1:0]  word_hit,
    output word_op_t          op
);
    localparam int WIDX_W = ADDR_W - SLOT_W;

    logic [SLOT_W-1:0] slot;
    logic [WIDX_W-1:0] widx;

    assign slot = addr[SLOT_W-1:0];
    assign widx = addr[ADDR_W-1:SLOT_W];

    always_comb begin
        op         = '0;
        op.en_set  = wr_en && (slot == SLOT_EN_SET);
        op.en_clr  = wr_en && (slot == SLOT_EN_CLR);
        op.sel_set = wr_en && (slot == SLOT_SEL_SET);
        op.sel_clr = wr_en && (slot == SLOT_SEL_CLR);
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_hit
        assign word_hit[w] = (widx == WIDX_W'(w));
    end
endmodule

// File: rtl/pad_pull_word.sv
module pad_pull_word
    import pad_pull_pkg::*;
#(
    parameter int WORD_IDX = 0,
    parameter int WORD_W   = 16,
    parameter int NUM_PINS = 134
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  word_op_t          op,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] en_q,
    output logic [WORD_W-1:0] sel_q
);
    logic [WORD_W-1:0] en_mask;
    logic [WORD_W-1:0] sel_mask;
    logic [WORD_W-1:0] en_d;
    logic [WORD_W-1:0] sel_d;

    for (genvar b = 0; b < WORD_W; b++) begin : g_mask
        localparam int PIN = WORD_IDX * WORD_W + b;
        assign sel_mask[b] = (PIN < NUM_PINS);
        assign en_mask[b]  = (PIN < NUM_PINS) && !pin_reserved(PIN);
    end

    always_comb begin
        en_d  = en_q;
        sel_d = sel_q;
        if (hit) begin
            if (op.en_set)  en_d  = en_q  |  wdata;
            if (op.en_clr)  en_d  = en_q  & ~wdata;
            if (op.sel_set) sel_d = sel_q |  wdata;
            if (op.sel_clr) sel_d = sel_q & ~wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            sel_q <= '0;
        end else begin
            en_q  <= en_d & en_mask;
            sel_q <= sel_d & sel_mask;
        end
    end
endmodule

// File: rtl/pad_pull_readmux.sv
module pad_pull_readmux
    import pad_pull_pkg::*;
#(
    parameter int WORDS  = 9,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [WORDS-1:0][WORD_W-1:0]  en_words,
    input  logic [WORDS-1:0][WORD_W-1:0]  sel_words,
    output logic [WORD_W-1:0]             data
);
    localparam int WIDX_W = ADDR_W - SLOT_W;

    logic [SLOT_W-1:0] slot;
    logic [WIDX_W-1:0] widx;

    assign slot = addr[SLOT_W-1:0];
    assign widx = addr[ADDR_W-1:SLOT_W];

    always_comb begin
        data = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (widx == WIDX_W'(w)) begin
                if (slot == SLOT_EN_VAL)  data = en_words[w];
                if (slot == SLOT_SEL_VAL) data = sel_words[w];
            end
        end
    end
endmodule

// File: rtl/pad_pull_bank.sv
module pad_pull_bank
    import pad_pull_pkg::*;
#(
    parameter  int NUM_PINS = DEF_PINS,
    parameter  int WORD_W   = DEF_WORD_W,
    localparam int WORDS    = words_for(NUM_PINS, WORD_W),
    localparam int ADDR_W   = $clog2(WORDS) + SLOT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rd_data,
    output logic [NUM_PINS-1:0] pull_up,
    output logic [NUM_PINS-1:0] pull_down
);
    logic [WORDS-1:0]              word_hit;
    word_op_t                      op;
    logic [WORDS-1:0][WORD_W-1:0]  en_words;
    logic [WORDS-1:0][WORD_W-1:0]  sel_words;
    logic [WORD_W-1:0]             rd_next;
    logic [WORDS*WORD_W-1:0]       en_flat;
    logic [WORDS*WORD_W-1:0]       sel_flat;

    pad_pull_decode #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_decode (
        .wr_en    (wr_en),
        .addr     (addr),
        .word_hit (word_hit),
        .op       (op)
    );

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        pad_pull_word #(
            .WORD_IDX (w),
            .WORD_W   (WORD_W),
            .NUM_PINS (NUM_PINS)
        ) u_word (
            .clk   (clk),
            .rst   (rst),
            .hit   (word_hit[w]),
            .op    (op),
            .wdata (wdata),
            .en_q  (en_words[w]),
            .sel_q (sel_words[w])
        );
    end

    pad_pull_readmux #(.WORDS(WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rmux (
        .addr      (addr),
        .en_words  (en_words),
        .sel_words (sel_words),
        .data      (rd_next)
    );

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    assign en_flat  = en_words;
    assign sel_flat = sel_words;

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            pull_up[p]   = en_flat[p] &  sel_flat[p];
            pull_down[p] = en_flat[p] & ~sel_flat[p];
        end
    end
endmodule

// File: rtl/pad_pull_bank_chk.sv
module pad_pull_bank_chk
    import pad_pull_pkg::*;
#(
    parameter int NUM_PINS = DEF_PINS,
    parameter int WORD_W   = DEF_WORD_W,
    parameter int ADDR_W   = 7
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [WORD_W-1:0]   wdata,
    input logic [WORD_W-1:0]   rd_data,
    input logic [NUM_PINS-1:0] pull_up,
    input logic [NUM_PINS-1:0] pull_down
);
    localparam int WORDS  = words_for(NUM_PINS, WORD_W);
    localparam int WIDX_W = ADDR_W - SLOT_W;

    logic [NUM_PINS-1:0] res_mask;
    logic [SLOT_W-1:0]   slot;
    logic                word_ok;
    logic                alias_slot;

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) res_mask[p] = pin_reserved(p);
    end

    assign slot       = addr[SLOT_W-1:0];
    assign word_ok    = (addr[ADDR_W-1:SLOT_W] < WIDX_W'(WORDS));
    assign alias_slot = (slot != SLOT_EN_VAL) && (slot != SLOT_SEL_VAL);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pull_up == '0 && pull_down == '0 && rd_data == '0));

    // R7
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((pull_up & res_mask) == '0) && ((pull_down & res_mask) == '0));

    // R9
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (!word_ok || slot == SLOT_EN_VAL || slot == SLOT_SEL_VAL ||
                   slot == 3'd3 || slot == 3'd7))
        |=> ($stable(pull_up) && $stable(pull_down)));

    // R8
    alias_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (alias_slot || !word_ok)) |=> (rd_data == '0));

    // R4
    word0_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(SLOT_EN_CLR) && wdata == '1)
        |=> (pull_up[WORD_W-1:0] == '0 && pull_down[WORD_W-1:0] == '0));

    // R6
    no_double_pull_chk: assert property (@(posedge clk) disable iff (rst)
        (pull_up & pull_down) == '0);
endmodule

bind pad_pull_bank pad_pull_bank_chk #(
    .NUM_PINS (NUM_PINS),
    .WORD_W   (WORD_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rd_data   (rd_data),
    .pull_up   (pull_up),
    .pull_down (pull_down)
);

// File: tb/pad_pull_bank_bench.sv
module pad_pull_bank_bench;
    localparam int NP   = 134;
    localparam int WW   = 16;
    localparam int NW   = 9;
    localparam int AW   = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] wdata = '0;
    logic [WW-1:0] rd_data;
    logic [NP-1:0] pull_up;
    logic [NP-1:0] pull_down;

    int n_cmp = 0;
    int n_bad = 0;

    bit m_en  [NP];
    bit m_sel [NP];

    always #10 clk = ~clk;

    pad_pull_bank u_pad_pull_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rd_data   (rd_data),
        .pull_up   (pull_up),
        .pull_down (pull_down)
    );

    function automatic bit skip_pin(input int p);
        if (p >= 22 && p <= 27)   return 1;
        if (p >= 47 && p <= 68)   return 1;
        if (p >= 73 && p <= 78)   return 1;
        if (p >= 100 && p <= 105) return 1;
        if (p >= 119 && p <= 124) return 1;
        return 0;
    endfunction

    function automatic logic [AW-1:0] mk(input int word, input int slot);
        return AW'(word * 8 + slot);
    endfunction

    function automatic logic [WW-1:0] model_read(input logic [AW-1:0] a);
        int word = int'(a) / 8;
        int slot = int'(a) % 8;
        logic [WW-1:0] r = '0;
        if (word < NW) begin
            for (int b = 0; b < WW; b++) begin
                int p = word * WW + b;
                if (p < NP) begin
                    if (slot == 0) r[b] = m_en[p];
                    if (slot == 4) r[b] = m_sel[p];
                end
            end
        end
        return r;
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [WW-1:0] d);
        int word = int'(a) / 8;
        int slot = int'(a) % 8;
        if (word < NW) begin
            for (int b = 0; b < WW; b++) begin
                int p = word * WW + b;
                if (p < NP && d[b]) begin
                    case (slot)
                        1: if (!skip_pin(p)) m_en[p] = 1;
                        2: m_en[p]  = 0;
                        5: m_sel[p] = 1;
                        6: m_sel[p] = 0;
                        default: ;
                    endcase
                end
            end
        end
    endtask

    task automatic check(input bit ok, input string req,
                         input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [WW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        model_write(a, d);
    endtask

    task automatic bus_read_check(input logic [AW-1:0] a, input string req);
        logic [WW-1:0] exp;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp = model_read(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data == exp, req, NP'(rd_data), NP'(exp));
    endtask

    task automatic check_pins(input string req);
        logic [NP-1:0] eu, ed;
        for (int p = 0; p < NP; p++) begin
            eu[p] = m_en[p] &  m_sel[p];
            ed[p] = m_en[p] & ~m_sel[p];
        end
        check(pull_up == eu, {req, " pull_up"}, pull_up, eu);
        check(pull_down == ed, {req, " pull_down"}, pull_down, ed);
    endtask

    task automatic t_reset;
        check_pins("R1");
        bus_read_check(mk(0, 0), "R1");
        bus_read_check(mk(8, 4), "R1");
    endtask

    task automatic t_pull_up_order;
        bus_write(mk(0, 5), 16'h0020);
        check_pins("R5 select stored, no pull while disabled");
        bus_write(mk(0, 1), 16'h0020);
        check_pins("R3 R6 pin5 pull_up");
        bus_read_check(mk(0, 0), "R2 R8 enable word0");
        bus_read_check(mk(0, 4), "R2 R8 select word0");
    endtask

    task automatic t_pull_down;
        bus_write(mk(8, 6), 16'h0004);
        bus_write(mk(8, 1), 16'h0004);
        check_pins("R5 R6 pin130 pull_down");
        bus_write(mk(8, 5), 16'h0004);
        check_pins("R5 pin130 flips to pull_up");
    endtask

    task automatic t_zero_bits;
        bus_write(mk(0, 1), 16'h0000);
        bus_write(mk(0, 2), 16'h0000);
        bus_write(mk(0, 6), 16'h0000);
        check_pins("R3 R4 zero bits no effect");
    endtask

    task automatic t_clear;
        bus_write(mk(0, 1), 16'h8001);
        check_pins("R3 multi-bit set");
        bus_write(mk(0, 2), 16'h0021);
        check_pins("R4 clear pins 0 and 5");
        bus_read_check(mk(0, 0), "R4 enable word0 readback");
    endtask

    task automatic t_reserved;
        bus_write(mk(1, 5), 16'hFFFF);
        bus_write(mk(1, 1), 16'hFFFF);
        check_pins("R7 word1 reserved pins stay off");
        bus_read_check(mk(1, 0), "R7 word1 enable readback");
        bus_write(mk(3, 1), 16'hFFFF);
        bus_read_check(mk(3, 0), "R7 fully reserved word3");
        bus_write(mk(7, 6), 16'hFFFF);
        bus_write(mk(7, 1), 16'hFFFF);
        check_pins("R7 word7 pins 119-124 stay off");
    endtask

    task automatic t_ignored;
        logic [NP-1:0] u0, d0;
        u0 = pull_up; d0 = pull_down;
        bus_write(mk(2, 0), 16'hFFFF);
        bus_write(mk(2, 4), 16'hFFFF);
        bus_write(mk(2, 3), 16'hFFFF);
        bus_write(mk(2, 7), 16'hFFFF);
        bus_write(mk(9, 1), 16'hFFFF);
        bus_write(mk(15, 1), 16'hFFFF);
        check(pull_up == u0 && pull_down == d0, "R9 ignored writes",
              pull_up ^ u0, '0);
        bus_read_check(mk(2, 0), "R9 word2 enable unchanged");
        bus_read_check(mk(2, 4), "R9 word2 select unchanged");
    endtask

    task automatic t_alias_reads;
        bus_read_check(mk(1, 1), "R8 enable-set slot reads 0");
        bus_read_check(mk(1, 6), "R8 select-clear slot reads 0");
        bus_read_check(mk(1, 3), "R8 unused slot reads 0");
        bus_read_check(mk(10, 0), "R8 out-of-range word reads 0");
    endtask

    task automatic t_tail;
        bus_write(mk(8, 5), 16'hFFFF);
        bus_write(mk(8, 1), 16'hFFFF);
        bus_read_check(mk(8, 0), "R10 tail enable bits");
        bus_read_check(mk(8, 4), "R10 tail select bits");
        check_pins("R10 pins 128-133 pull_up");
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int p = 0; p < NP; p++) begin m_en[p] = 0; m_sel[p] = 0; end
        check_pins("R1 reset after activity");
        bus_read_check(mk(1, 4), "R1 select cleared");
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin m_en[p] = 0; m_sel[p] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pull_up_order();
        t_pull_down();
        t_zero_bits();
        t_clear();
        t_reserved();
        t_ignored();
        t_alias_reads();
        t_tail();
        t_reset_again();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule